// File: doc/BRIEF.md
# Inverting-Operand Arithmetic Logic Unit

A combinational arithmetic logic unit that produces AND, OR, add, subtract, signed set-on-less-than and NOR from a single ripple adder and a single AND/OR stage. Two operand-conditioning controls make this possible. One flips operand A. The other flips operand B and also drives the adder carry-in high, so the adder computes A minus B. All of the non-trivial operations come from combining these controls with a 2-bit result picker.

The block sits in the execute stage of a simple integer datapath. Upstream decode logic drives the 4-bit select. The zero flag serves as the equality test for branch-on-equal after a subtraction. The signed overflow flag and the carry flag are only meaningful for add and subtract, and are held low for every other select. The less-than bit is corrected for subtraction overflow before it is placed on bit 0, so signed comparisons across the whole range give the right answer.

Top module: `alu_core`

## Requirements
- R1: The select word `sel_i` is decoded as follows. Bit 3 inverts operand A. Bit 2 inverts operand B and forces the adder carry-in to 1. Bits 1..0 pick the result: 00 AND, 01 OR, 10 adder sum, 11 less-than bit. The legal codes are 0000, 0001, 0010, 0110, 0111 and 1100.
- R2: With select 0000 the result is A AND B. With select 0001 the result is A OR B. Overflow and carry are 0 for both.
- R3: With select 0010 the result is (A + B) mod 2^WIDTH, and `carry_o` is the carry out of the top bit.
- R4: With select 0110 the result is (A − B) mod 2^WIDTH. `carry_o` is the carry out of A + ~B + 1, which is 1 exactly when A ≥ B unsigned.
- R5: With select 1100 the result is NOR(A, B). Overflow and carry are 0.
- R6: With select 0111, bit 0 of the result is 1 exactly when A < B as signed numbers, and all other bits are 0. This holds even when the difference overflows: for WIDTH = 32, A = 0x80000000 and B = 0x00000001 gives 1. Overflow and carry are 0.
- R7: `overflow_o` is 1 only for selects 0010 and 0110, and only when the signed result is not representable in WIDTH bits. It is 0 for every other select.
- R8: `zero_o` is 1 exactly when every bit of `result_o` is 0, whatever the select.
- R9: Any select code outside the legal set gives a result of 0, with overflow 0 and carry 0. As a consequence, `zero_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| sel_i | input | 4 | Operation select (A-invert, B-negate, result picker) |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| overflow_o | output | 1 | Signed overflow for add and subtract |
| carry_o | output | 1 | Adder carry out for add and subtract |

## Verification
Immediate assertions inside the design hold on every evaluation, and they cover four behaviours:
- The ripple adder matches arithmetic addition.
- The add and subtract selects produce the arithmetic sum and difference.
- Set-on-less-than clears all upper bits and matches a signed comparison.
- Overflow and carry stay low outside add and subtract, and illegal codes give an all-zero result.

The zero flag, the carry semantics of subtraction, AND, OR and NOR, and the overflow-corrected less-than corner are shown only by the bench. The bench sweeps a 4-bit instance exhaustively over all operands and all sixteen selects. It also drives the 32-bit instance with sign-boundary corner values and random operands, and compares every output against an arithmetic model.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    PICK_AND  = 2'b00,
    PICK_OR   = 2'b01,
    PICK_SUM  = 2'b10,
    PICK_LESS = 2'b11
  } pick_e;

  typedef struct packed {
    logic  a_inv;
    logic  b_neg;
    pick_e pick;
  } sel_t;

  localparam logic [3:0] SEL_AND = 4'b0000;
  localparam logic [3:0] SEL_OR  = 4'b0001;
  localparam logic [3:0] SEL_ADD = 4'b0010;
  localparam logic [3:0] SEL_SUB = 4'b0110;
  localparam logic [3:0] SEL_SLT = 4'b0111;
  localparam logic [3:0] SEL_NOR = 4'b1100;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0] sel_i,
  output sel_t       ctl_o,
  output logic       valid_o,
  output logic       arith_o
);

  assign ctl_o = sel_t'(sel_i);

  always_comb begin
    valid_o = 1'b0;
    arith_o = 1'b0;
    unique case (sel_i)
      SEL_AND, SEL_OR, SEL_SLT, SEL_NOR: valid_o = 1'b1;
      SEL_ADD, SEL_SUB: begin
        valid_o = 1'b1;
        arith_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  logic [WIDTH:0] carry;
  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum_o[i]     = a_i[i] ^ b_i[i] ^ carry[i];
    assign carry[i+1]   = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = carry[WIDTH];
  // signed overflow: carry into msb differs from carry out of msb
  assign ovf_o  = carry[WIDTH] ^ carry[WIDTH-1];

  always_comb begin
    p_ripple_sum_r3: assert ({cout_o, sum_o} ==
                             ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}));
  end

endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  pick_e            pick_i,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] and_i,
  input  logic [WIDTH-1:0] or_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             less_i,
  output logic [WIDTH-1:0] result_o
);

  always_comb begin
    result_o = '0;
    if (valid_i) begin
      unique case (pick_i)
        PICK_AND:  result_o = and_i;
        PICK_OR:   result_o = or_i;
        PICK_SUM:  result_o = sum_i;
        PICK_LESS: result_o = {{(WIDTH-1){1'b0}}, less_i};
        default:   result_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o,
  output logic             carry_o
);

  localparam int unsigned Msb = WIDTH - 1;

  sel_t             ctl;
  logic             valid;
  logic             arith;
  logic [WIDTH-1:0] a_op, b_op;
  logic [WIDTH-1:0] sum;
  logic             cout, ovf_raw, less;

  alu_decode u_decode (
    .sel_i   (sel_i),
    .ctl_o   (ctl),
    .valid_o (valid),
    .arith_o (arith)
  );

  assign a_op = ctl.a_inv ? ~a_i : a_i;
  assign b_op = ctl.b_neg ? ~b_i : b_i;

  alu_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i    (a_op),
    .b_i    (b_op),
    .cin_i  (ctl.b_neg),
    .sum_o  (sum),
    .cout_o (cout),
    .ovf_o  (ovf_raw)
  );

  // sign of difference corrected by overflow
  assign less = sum[Msb] ^ ovf_raw;

  alu_result_mux #(.WIDTH(WIDTH)) u_mux (
    .pick_i   (ctl.pick),
    .valid_i  (valid),
    .and_i    (a_op & b_op),
    .or_i     (a_op | b_op),
    .sum_i    (sum),
    .less_i   (less),
    .result_o (result_o)
  );

  assign zero_o     = ~|result_o;
  assign overflow_o = arith & ovf_raw;
  assign carry_o    = arith & cout;

  always_comb begin
    if (sel_i == SEL_ADD)
      p_add_value_r3: assert (result_o == a_i + b_i);
    if (sel_i == SEL_SUB)
      p_sub_value_r4: assert (result_o == a_i - b_i);
    if (sel_i == SEL_SLT)
      p_slt_value_r6: assert (result_o[Msb:1] == '0 &&
                              result_o[0] == ($signed(a_i) < $signed(b_i)));
    if (sel_i != SEL_ADD && sel_i != SEL_SUB)
      p_no_overflow_r7: assert (!overflow_o && !carry_o);
    if (!valid)
      p_illegal_code_r9: assert (result_o == '0 && !overflow_o);
  end

endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] a32, b32, r32;
  logic [3:0]  a4, b4, r4;
  logic [3:0]  sel;
  logic z32, o32, c32, z4, o4, c4;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  alu_core #(.WIDTH(32)) dut_i (
    .a_i(a32), .b_i(b32), .sel_i(sel),
    .result_o(r32), .zero_o(z32), .overflow_o(o32), .carry_o(c32)
  );

  alu_core #(.WIDTH(4)) dut_s_i (
    .a_i(a4), .b_i(b4), .sel_i(sel),
    .result_o(r4), .zero_o(z4), .overflow_o(o4), .carry_o(c4)
  );

  function automatic string op_tag(input logic [3:0] s);
    case (s)
      4'b0000, 4'b0001: return "R2";
      4'b0010:          return "R3";
      4'b0110:          return "R4";
      4'b1100:          return "R5";
      4'b0111:          return "R6";
      default:          return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s sel=%b actual=%0h expected=%0h", tag, what, sel, act, exp);
    end
  endtask

  // arithmetic reference model
  task automatic model(input int w, input longint unsigned a, input longint unsigned b,
                       input logic [3:0] s, output longint unsigned r,
                       output bit ov, output bit cy);
    longint unsigned m = (64'd1 << w) - 1;
    longint unsigned aa = a & m, bb = b & m, full;
    longint sa, sb;
    bit na = aa[w-1], nb = bb[w-1];
    r = 0; ov = 0; cy = 0;
    sa = na ? longint'(aa) - longint'(64'd1 << w) : longint'(aa);
    sb = nb ? longint'(bb) - longint'(64'd1 << w) : longint'(bb);
    case (s)
      4'b0000: r = aa & bb;
      4'b0001: r = aa | bb;
      4'b1100: r = ~(aa | bb) & m;
      4'b0111: r = (sa < sb) ? 1 : 0;
      4'b0010: begin
        full = aa + bb; r = full & m; cy = full[w];
        ov = (sa + sb > longint'(m >> 1)) || (sa + sb < -longint'((m >> 1) + 1));
      end
      4'b0110: begin
        full = aa + (~bb & m) + 1; r = full & m; cy = full[w];
        ov = (sa - sb > longint'(m >> 1)) || (sa - sb < -longint'((m >> 1) + 1));
      end
      default: r = 0;
    endcase
  endtask

  task automatic run_big(input logic [31:0] a, input logic [31:0] b, input logic [3:0] s);
    longint unsigned er; bit eo, ec;
    @(posedge clk);
    a32 = a; b32 = b; sel = s;
    model(32, a, b, s, er, eo, ec);
    @(negedge clk);
    check(r32 == er[31:0], op_tag(s), "result32", r32, er);
    check(o32 == eo, "R7", "overflow32", o32, eo);
    check(c32 == ec, op_tag(s), "carry32", c32, ec);
    check(z32 == (er == 0), "R8", "zero32", z32, er == 0);
  endtask

  task automatic run_small(input logic [3:0] a, input logic [3:0] b, input logic [3:0] s);
    longint unsigned er; bit eo, ec;
    @(posedge clk);
    a4 = a; b4 = b; sel = s;
    model(4, a, b, s, er, eo, ec);
    @(negedge clk);
    check(r4 == er[3:0], op_tag(s), "result4", r4, er);
    check(o4 == eo, "R7", "overflow4", o4, eo);
    check(c4 == ec, op_tag(s), "carry4", c4, ec);
    check(z4 == (er == 0), "R8", "zero4", z4, er == 0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] corners [8];
    corners = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                32'hFFFFFFFF, 32'h80000001, 32'h55555555, 32'hAAAAAAAA};
    a32 = '0; b32 = '0; a4 = '0; b4 = '0; sel = 4'b0000;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state: AND of zeros
    check(r32 == 0 && z32 == 1'b1, "R8", "idle32", {r32, z32}, 1);
    check(o32 == 1'b0 && c32 == 1'b0, "R7", "idle_flags", {o32, c32}, 0);

    // R6 overflow corner of the less-than bit
    run_big(32'h80000000, 32'h00000001, 4'b0111);
    check(r32 == 32'h1, "R6", "slt_overflow_corner", r32, 1);
    run_big(32'h7FFFFFFF, 32'h80000000, 4'b0111);
    check(r32 == 32'h0, "R6", "slt_overflow_reverse", r32, 0);
    // R4 equality feeds zero flag
    run_big(32'h12345678, 32'h12345678, 4'b0110);
    check(z32 == 1'b1 && c32 == 1'b1, "R4", "sub_equal", {z32, c32}, 3);
    // R1 invert fields: NOR built from both inverts
    run_big(32'hF0F0F0F0, 32'h0FF00FF0, 4'b1100);
    check(r32 == 32'h000F000F, "R1", "nor_via_inverts", r32, 32'h000F000F);

    // exhaustive small sweep, all selects
    for (int s = 0; s < 16; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_small(4'(a), 4'(b), 4'(s));

    // corner matrix on the 32-bit instance
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_big(corners[i], corners[j], 4'(s));

    // random operands over legal codes
    for (int k = 0; k < 1500; k++) begin
      logic [3:0] codes [6];
      codes = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
      run_big($urandom, $urandom, codes[k % 6]);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule